// File: doc/BRIEF.md
# Register Knock Unlock Detector

This block keeps an add-on peripheral invisible on a host bus until software proves it knows the peripheral is there. The proof is an ordered pair of byte writes to a single knock address. Until that pair has been seen, writes and reads aimed at the peripheral's register window are not passed on. A read of the knock address returns the all-ones byte that an unpopulated address gives on the stock machine.

Once the pair has been written, the block raises a registered enable. That enable forwards window accesses to the peripheral, and from then on a read of the knock address reports zero. Software can read the knock address first: a value other than all-ones means the peripheral is already active and the knock can be skipped.

The sequence tracker is a three-state machine:
- `ST_LOCKED` (reset state) moves to `ST_ARMED` on a knock write of the first key.
- `ST_ARMED` moves to `ST_OPEN` on a knock write of the second key.
- `ST_ARMED` stays in `ST_ARMED` on a knock write of the first key. That key restarts the sequence.
- `ST_ARMED` falls back to `ST_LOCKED` on a knock write of any other value.
- `ST_ARMED` stays where it is on writes to any other address.
- `ST_OPEN` is terminal until reset.

Top module: `knock_unlock`

## Requirements
- R1: After reset `periph_en` is 0, `rd_valid` is 0, and the tracker is in `ST_LOCKED`.
- R2: While `periph_en` is 0, writes and reads to the peripheral window (page 0xD0, offsets 0x31 to 0x3F) leave `periph_wr` and `periph_rd` at 0.
- R3: While locked, a read of the knock address 0xD030 produces `rd_valid`=1 with `rd_data`=0xFF in the following cycle.
- R4: A knock write of 0x42 followed by a knock write of 0x52 sets `periph_en` to 1 in the cycle after the 0x52 write. During the 0x52 write cycle itself, `periph_en` is still 0.
- R5: While unlocked, a read of 0xD030 produces `rd_valid`=1 with `rd_data`=0x00 in the following cycle.
- R6: After 0x42, a knock write of any value other than 0x52 or 0x42 returns the tracker to `ST_LOCKED`. A later lone 0x52 then does not unlock.
- R7: After 0x42, a further knock write of 0x42 keeps the tracker armed, so a following 0x52 unlocks.
- R8: Writes to other addresses between the two key writes do not break the sequence.
- R9: Once unlocked, the block stays unlocked until reset, whatever is later written to the knock address.
- R10: While unlocked, a window write or read asserts `periph_wr` or `periph_rd` in the same cycle. A knock address write never asserts `periph_wr`.
- R11: A knock read issued in the same cycle as the unlocking 0x52 write returns 0xFF, the state before that write.
- R12: A 0x52 written without a preceding 0x42 does not unlock. Key bytes written to an address outside page 0xD0 (for example 0xD130) are not knock writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 16 | Host bus address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_wdata | input | 8 | Write data |
| rd_valid | output | 1 | Knock read data valid, one cycle after a knock read |
| rd_data | output | 8 | Knock read value (0xFF locked, 0x00 unlocked) |
| periph_wr | output | 1 | Write strobe passed to the peripheral window |
| periph_rd | output | 1 | Read strobe passed to the peripheral window |
| periph_en | output | 1 | Registered unlock enable |

## Verification
The unlocking second key write and a knock read can land in the same cycle. The read must report the value from before the write (0xFF), and the enable must rise only on the next cycle. The bench provokes this by raising the read and write strobes together at 0xD030 with data 0x52. A scoreboard queue holds the expected 0xFF and, after it, the 0x00 from a later read, and the monitor pops each entry when `rd_valid` appears. `periph_en` is sampled both in the write cycle and in the cycle after it.

// File: rtl/knock_pkg.sv
package knock_pkg;

    typedef enum logic [1:0] {
        ST_LOCKED = 2'd0,
        ST_ARMED  = 2'd1,
        ST_OPEN   = 2'd2
    } knock_state_t;

    localparam logic [7:0] KEY_FIRST  = 8'h42;
    localparam logic [7:0] KEY_SECOND = 8'h52;
    localparam logic [7:0] RD_LOCKED  = 8'hFF;
    localparam logic [7:0] RD_OPEN    = 8'h00;

endpackage

// File: rtl/knock_decode.sv
module knock_decode #(
    parameter int          ADDR_W    = 16,
    parameter logic [7:0]  PAGE      = 8'hD0,
    parameter logic [7:0]  KNOCK_OFS = 8'h30,
    parameter logic [7:0]  WIN_LO    = 8'h31,
    parameter logic [7:0]  WIN_HI    = 8'h3F
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              is_knock,
    output logic              in_win
);
    localparam int PAGE_W = ADDR_W - 8;

    logic [PAGE_W-1:0] page_bits;
    logic [7:0]        ofs;
    logic              page_hit;

    always_comb begin
        page_bits = addr[ADDR_W-1:8];
        ofs       = addr[7:0];
        page_hit  = (page_bits == PAGE_W'(PAGE));
        is_knock  = page_hit && (ofs == KNOCK_OFS);
        in_win    = page_hit && (ofs >= WIN_LO) && (ofs <= WIN_HI);
    end

endmodule

// File: rtl/knock_fsm.sv
module knock_fsm
    import knock_pkg::*;
#(
    parameter int         DATA_W = 8,
    parameter logic [7:0] KEY_A  = KEY_FIRST,
    parameter logic [7:0] KEY_B  = KEY_SECOND
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              knock_wr,
    input  logic [DATA_W-1:0] wdata,
    output logic              unlocked
);
    knock_state_t state, state_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_LOCKED;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_LOCKED: begin
                if (knock_wr && wdata == DATA_W'(KEY_A)) state_nx = ST_ARMED;
            end
            ST_ARMED: begin
                if (knock_wr) begin
                    if (wdata == DATA_W'(KEY_B))      state_nx = ST_OPEN;
                    else if (wdata == DATA_W'(KEY_A)) state_nx = ST_ARMED;
                    else                              state_nx = ST_LOCKED;
                end
            end
            ST_OPEN:  state_nx = ST_OPEN;
            default:  state_nx = ST_LOCKED;
        endcase
    end

    always_comb begin
        unlocked = (state == ST_OPEN);
    end

    a_r4_open_after_key: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ARMED && knock_wr && wdata == DATA_W'(KEY_B)) |=> unlocked);

    a_r9_stays_open: assert property (@(posedge clk) disable iff (!rst_n)
        unlocked |=> unlocked);

    a_r6_bad_key_rewinds: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ARMED && knock_wr && wdata != DATA_W'(KEY_B)
         && wdata != DATA_W'(KEY_A)) |=> (state == ST_LOCKED));

    a_r12_open_only_from_armed: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(unlocked) |-> ($past(state) == ST_ARMED));

endmodule

// File: rtl/knock_gate.sv
module knock_gate
    import knock_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic              is_knock,
    input  logic              in_win,
    input  logic              unlocked,
    output logic              periph_wr,
    output logic              periph_rd,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);
    always_comb begin
        periph_wr = bus_wr && in_win && unlocked;
        periph_rd = bus_rd && in_win && unlocked;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= bus_rd && is_knock;
            if (bus_rd && is_knock)
                rd_data <= unlocked ? DATA_W'(RD_OPEN) : DATA_W'(RD_LOCKED);
        end
    end

    a_r3_locked_read: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && is_knock && !unlocked) |=> (rd_valid && rd_data == DATA_W'(RD_LOCKED)));

    a_r5_open_read: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && is_knock && unlocked) |=> (rd_valid && rd_data == DATA_W'(RD_OPEN)));

endmodule

// File: rtl/knock_unlock.sv
module knock_unlock
    import knock_pkg::*;
#(
    parameter int         ADDR_W    = 16,
    parameter int         DATA_W    = 8,
    parameter logic [7:0] PAGE      = 8'hD0,
    parameter logic [7:0] KNOCK_OFS = 8'h30,
    parameter logic [7:0] WIN_LO    = 8'h31,
    parameter logic [7:0] WIN_HI    = 8'h3F
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              periph_wr,
    output logic              periph_rd,
    output logic              periph_en
);
    logic is_knock;
    logic in_win;
    logic unlocked;

    knock_decode #(
        .ADDR_W(ADDR_W), .PAGE(PAGE), .KNOCK_OFS(KNOCK_OFS),
        .WIN_LO(WIN_LO), .WIN_HI(WIN_HI)
    ) u_decode (
        .addr(bus_addr), .is_knock(is_knock), .in_win(in_win)
    );

    knock_fsm #(.DATA_W(DATA_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .knock_wr(bus_wr && is_knock),
        .wdata(bus_wdata), .unlocked(unlocked)
    );

    knock_gate #(.DATA_W(DATA_W)) u_gate (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .is_knock(is_knock), .in_win(in_win), .unlocked(unlocked),
        .periph_wr(periph_wr), .periph_rd(periph_rd),
        .rd_valid(rd_valid), .rd_data(rd_data)
    );

    always_comb periph_en = unlocked;

    a_r10_knock_not_forwarded: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && is_knock) |-> !periph_wr);

endmodule

// File: tb/test_knock_unlock.sv
module test_knock_unlock;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic        rd_valid;
    logic [7:0]  rd_data;
    logic        periph_wr;
    logic        periph_rd;
    logic        periph_en;

    int checks = 0;
    int errors = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #2.5 clk = ~clk;

    knock_unlock i_knock_unlock (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .rd_valid(rd_valid),
        .rd_data(rd_data), .periph_wr(periph_wr), .periph_rd(periph_rd),
        .periph_en(periph_en)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [15:0] a, input logic w, input logic r, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wr = w; bus_rd = r; bus_wdata = d;
        #1;
    endtask

    task automatic idle();
        drive(16'h0000, 1'b0, 1'b0, 8'h00);
    endtask

    task automatic knock_read(input logic [7:0] exp, input string req);
        exp_q.push_back(exp);
        tag_q.push_back(req);
        drive(16'hD030, 1'b0, 1'b1, 8'h00);
    endtask

    // monitor: registered read results seen at the falling edge
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R3/R5 unexpected rd_valid", 1, 0);
            end else begin
                logic [7:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(rd_data == e, t, rd_data, e);
            end
        end
    end

    initial begin
        #500000;
        check(1'b0, "watchdog", 0, 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle();
        // R1 reset state
        check(periph_en == 1'b0, "R1 periph_en", periph_en, 0);
        check(rd_valid == 1'b0, "R1 rd_valid", rd_valid, 0);

        // R3 locked read
        knock_read(8'hFF, "R3 locked knock read");
        idle();

        // R2 window quiet while locked
        drive(16'hD035, 1'b1, 1'b0, 8'hAA);
        check(periph_wr == 1'b0, "R2 periph_wr locked", periph_wr, 0);
        drive(16'hD03F, 1'b0, 1'b1, 8'h00);
        check(periph_rd == 1'b0, "R2 periph_rd locked", periph_rd, 0);

        // R12 lone second key, and keys in another page
        drive(16'hD030, 1'b1, 1'b0, 8'h52);
        idle();
        check(periph_en == 1'b0, "R12 lone 0x52", periph_en, 0);
        drive(16'hD130, 1'b1, 1'b0, 8'h42);
        drive(16'hD130, 1'b1, 1'b0, 8'h52);
        idle();
        check(periph_en == 1'b0, "R12 wrong page", periph_en, 0);

        // R6 bad second byte rewinds
        drive(16'hD030, 1'b1, 1'b0, 8'h42);
        drive(16'hD030, 1'b1, 1'b0, 8'h11);
        drive(16'hD030, 1'b1, 1'b0, 8'h52);
        idle();
        check(periph_en == 1'b0, "R6 rewind after bad byte", periph_en, 0);
        knock_read(8'hFF, "R6 still locked read");
        idle();

        // R7 repeated first key, R8 foreign write in between, R11 same-cycle read
        drive(16'hD030, 1'b1, 1'b0, 8'h42);
        drive(16'hD030, 1'b1, 1'b0, 8'h42);
        drive(16'hD040, 1'b1, 1'b0, 8'h77);
        drive(16'hD035, 1'b1, 1'b0, 8'h55);
        check(periph_en == 1'b0, "R8 still armed not open", periph_en, 0);
        exp_q.push_back(8'hFF);
        tag_q.push_back("R11 same-cycle read");
        drive(16'hD030, 1'b1, 1'b1, 8'h52);
        check(periph_en == 1'b0, "R4 not open in write cycle", periph_en, 0);
        idle();
        check(periph_en == 1'b1, "R4 R7 R8 open next cycle", periph_en, 1);

        // R5 unlocked read
        knock_read(8'h00, "R5 open knock read");
        idle();

        // R10 forwarding
        drive(16'hD035, 1'b1, 1'b0, 8'h5A);
        check(periph_wr == 1'b1, "R10 periph_wr open", periph_wr, 1);
        drive(16'hD031, 1'b0, 1'b1, 8'h00);
        check(periph_rd == 1'b1, "R10 periph_rd open", periph_rd, 1);
        drive(16'hD030, 1'b1, 1'b0, 8'h42);
        check(periph_wr == 1'b0, "R10 knock not forwarded", periph_wr, 0);

        // R9 sticky
        drive(16'hD030, 1'b1, 1'b0, 8'h00);
        drive(16'hD030, 1'b1, 1'b0, 8'hFF);
        idle();
        check(periph_en == 1'b1, "R9 sticky", periph_en, 1);
        knock_read(8'h00, "R9 read after rewrites");
        idle();
        idle();

        // R1 reset relocks
        rst_n = 1'b0;
        idle();
        rst_n = 1'b1;
        idle();
        check(periph_en == 1'b0, "R1 after reset", periph_en, 0);

        check(exp_q.size() == 0, "R3/R5 scoreboard drained", exp_q.size(), 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule